// File: doc/BRIEF.md
# Unaligned Access Splitter

This block sits between a processor's load/store path and a 32-bit, word-aligned data bus. It accepts one data access at a time, a byte, halfword or word at any byte address. It turns that access into the aligned bus transfers needed to carry it out. An access that fits inside one word goes out as a single transfer, with byte strobes that mark only the addressed lanes. An access whose bytes cross into the next word goes out as two transfers, one after the other: the lower word first, then the next word. For writes, the data is rotated across the two transfers. For reads, the bytes of the two transfers are joined into one little-endian result. The requester sees a single response in both cases, and the split access takes more cycles than an aligned one.

Some accesses must never be misaligned, and these are refused before any bus traffic. An access is misaligned when its address is not a multiple of its size. A misaligned access faults in each of these cases:

- unaligned support is switched off by the configuration input;
- the access belongs to a load/store-multiple sequence;
- the access is a stack push or pop;
- the access is exclusive;
- the address falls in one of the two single-bit alias windows.

A fault, or a bus error on either transfer, is reported in the single response.

Top module: `unaligned_splitter`

## Requirements
- R1: Every bus transfer has a word-aligned address and a non-zero strobe. An access whose bytes lie within one word (for example, a halfword at byte offset 1, strobe 4'b0110) produces exactly one transfer. Its strobe bit k is set for each addressed byte lane k, with lane k holding bits 8k+7:8k.
- R2: An access that crosses a word boundary (a halfword at offset 3, or a word at offset 1, 2 or 3) produces exactly two transfers. The first goes to the lower word, and the second goes to the lower word address plus 4. The second is presented in the cycle after the first is accepted. A transfer held by a low bus_ready keeps its address and strobe.
- R3: A read returns one response, a single-cycle rsp_valid pulse. Its rsp_rdata holds the addressed bytes, little-endian and zero-extended: the lowest-addressed byte goes in bits 7:0. Bytes from the upper part of the first word are joined with bytes from the lower part of the second word.
- R4: A write changes only the addressed bytes in each word it touches. Byte i of req_wdata lands at byte address req_addr+i.
- R5: When cfg_unaligned_en is 0, any misaligned access faults. A faulted access produces no bus transfer, and its response arrives in the cycle after the request is accepted. Aligned accesses still proceed.
- R6: A misaligned access that has req_multi, req_stack or req_excl set faults. The same flags on an aligned access have no effect.
- R7: A misaligned access whose address lies in either alias window faults. The windows are 32 MB each, at 0x2200_0000 and 0x4200_0000 by default. Aligned accesses and byte accesses into a window proceed normally.
- R8: A bus error on either transfer of an access sets rsp_err, never together with rsp_fault. The response waits until every issued transfer has returned.
- R9: req_size encodes 0 = byte, 1 = halfword, 2 = word. The code 3 always faults.
- R10: After reset, req_ready is 1, and bus_valid and rsp_valid are 0.
- R11: req_ready is 0 from acceptance until the response. It is 1 again in the cycle after rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_unaligned_en | input | 1 | 1 allows misaligned accesses to be split |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write data, lowest byte first |
| req_multi | input | 1 | Access is part of a load/store-multiple sequence |
| req_stack | input | 1 | Access is a stack push or pop |
| req_excl | input | 1 | Exclusive access |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 32 | Read result, zero for writes and faults |
| rsp_fault | output | 1 | Access refused for alignment reasons |
| rsp_err | output | 1 | A bus transfer returned an error |
| bus_valid | output | 1 | Transfer request |
| bus_ready | input | 1 | Transfer accepted |
| bus_addr | output | ADDR_W | Word-aligned transfer address |
| bus_write | output | 1 | Transfer direction |
| bus_strb | output | 4 | Byte-lane strobes |
| bus_wdata | output | 32 | Lane-aligned write data |
| bus_rvalid | input | 1 | Transfer completion, in issue order |
| bus_rdata | input | 32 | Read data of completed transfer |
| bus_rerr | input | 1 | Completed transfer failed |

## Verification
The hardest case to reach from the ports is an error on just one half of a split access. The bench reaches it with a bus model that fails every transfer to one chosen word. Split accesses are placed so that either the lower or the upper word is the failing one. The bench then checks two things: the other half still commits, and the single response waits for both completions. The back-to-back issue of the second transfer shows only with a bus that never stalls. The sweep therefore runs every size, offset and direction both with a stalling bus and with a never-stalling one.

// File: rtl/ua_pkg.sv
package ua_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BEAT0,
    ST_BEAT1,
    ST_DRAIN,
    ST_RESP
  } seq_state_e;

  // lanes touched across a two-word window, bit k = byte k of lower word
  function automatic logic [7:0] lane_span(input logic [1:0] off, input logic [1:0] sz);
    logic [7:0] base;
    case (sz)
      2'd0:    base = 8'h01;
      2'd1:    base = 8'h03;
      default: base = 8'h0F;
    endcase
    return base << off;
  endfunction

  function automatic logic is_misaligned(input logic [1:0] off, input logic [1:0] sz);
    case (sz)
      2'd0:    return 1'b0;
      2'd1:    return off[0];
      default: return off != 2'd0;
    endcase
  endfunction

  function automatic logic [31:0] join_read(input logic [31:0] lo, input logic [31:0] hi,
                                            input logic [1:0] off, input logic [1:0] sz);
    logic [63:0] win;
    win = {hi, lo} >> {off, 3'b000};
    case (sz)
      2'd0:    return {24'h0, win[7:0]};
      2'd1:    return {16'h0, win[15:0]};
      default: return win[31:0];
    endcase
  endfunction

  function automatic logic [63:0] spread_write(input logic [31:0] wd, input logic [1:0] off);
    return {32'h0, wd} << {off, 3'b000};
  endfunction

endpackage

// File: rtl/ua_classify.sv
module ua_classify
  import ua_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          N_WINDOWS  = 2,
  parameter logic [63:0] WIN_BASES  = {32'h4200_0000, 32'h2200_0000},
  parameter int          WIN_BITS   = 25
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              cfg_en,
  input  logic              multi,
  input  logic              stack,
  input  logic              excl,
  output logic              fault,
  output logic              split
);
  localparam logic [ADDR_W-1:0] HI_MASK = ~((ADDR_W'(1) << WIN_BITS) - ADDR_W'(1));

  logic [N_WINDOWS-1:0] win_hit;
  logic                 mis;
  logic [7:0]           span;

  for (genvar g = 0; g < N_WINDOWS; g++) begin : g_win
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(WIN_BASES[32*g +: 32]);
    assign win_hit[g] = (addr & HI_MASK) == (BASE & HI_MASK);
  end

  always_comb begin
    mis   = is_misaligned(addr[1:0], size);
    span  = lane_span(addr[1:0], size);
    split = |span[7:4];
    fault = (size == SZ_BAD) ||
            (mis && (!cfg_en || multi || stack || excl || (|win_hit)));
  end

endmodule

// File: rtl/ua_lane_map.sv
module ua_lane_map
  import ua_pkg::*;
(
  input  logic [1:0]  off,
  input  logic [1:0]  size,
  input  logic [31:0] wdata,
  input  logic [31:0] rd_lo,
  input  logic [31:0] rd_hi,
  output logic [31:0] wd_lo,
  output logic [31:0] wd_hi,
  output logic [3:0]  strb_lo,
  output logic [3:0]  strb_hi,
  output logic [31:0] rd_joined
);
  logic [63:0] wwin;
  logic [7:0]  span;

  always_comb begin
    wwin      = spread_write(wdata, off);
    span      = lane_span(off, size);
    wd_lo     = wwin[31:0];
    wd_hi     = wwin[63:32];
    strb_lo   = span[3:0];
    strb_hi   = span[7:4];
    rd_joined = join_read(rd_lo, rd_hi, off, size);
  end

endmodule

// File: rtl/ua_seq.sv
module ua_seq
  import ua_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_fire,
  input  logic        fault_c,
  input  logic        split_c,
  input  logic        bus_ready,
  input  logic        bus_rvalid,
  input  logic        bus_rerr,
  input  logic [31:0] bus_rdata,
  output logic        req_ready,
  output logic        bus_valid,
  output logic        beat_sel,
  output logic        rsp_valid,
  output logic        rsp_fault,
  output logic        rsp_err,
  output logic        cur_split,
  output logic        beat0_accept,
  output logic [31:0] rbuf_lo,
  output logic [31:0] rbuf_hi
);
  seq_state_e state_q, state_d;
  logic [1:0] rcnt_q, rcnt_nxt, need;
  logic       flt_q, err_q;

  assign need         = cur_split ? 2'd2 : 2'd1;
  assign rcnt_nxt     = rcnt_q + {1'b0, bus_rvalid};
  assign req_ready    = state_q == ST_IDLE;
  assign bus_valid    = (state_q == ST_BEAT0) || (state_q == ST_BEAT1);
  assign beat_sel     = state_q == ST_BEAT1;
  assign rsp_valid    = state_q == ST_RESP;
  assign rsp_fault    = flt_q;
  assign rsp_err      = err_q;
  assign beat0_accept = (state_q == ST_BEAT0) && bus_ready;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (req_fire) state_d = fault_c ? ST_RESP : ST_BEAT0;
      ST_BEAT0: if (bus_ready) state_d = cur_split ? ST_BEAT1 : ST_DRAIN;
      ST_BEAT1: if (bus_ready) state_d = ST_DRAIN;
      ST_DRAIN: if (rcnt_nxt == need) state_d = ST_RESP;
      ST_RESP:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      rcnt_q    <= '0;
      flt_q     <= 1'b0;
      err_q     <= 1'b0;
      cur_split <= 1'b0;
      rbuf_lo   <= '0;
      rbuf_hi   <= '0;
    end else begin
      state_q <= state_d;
      if (req_fire) begin
        rcnt_q    <= '0;
        flt_q     <= fault_c;
        err_q     <= 1'b0;
        cur_split <= split_c && !fault_c;
        rbuf_lo   <= '0;
        rbuf_hi   <= '0;
      end else if (bus_rvalid && state_q != ST_IDLE) begin
        rcnt_q <= rcnt_nxt;
        err_q  <= err_q | bus_rerr;
        if (rcnt_q == 2'd0) rbuf_lo <= bus_rdata;
        else                rbuf_hi <= bus_rdata;
      end
    end
  end

endmodule

// File: rtl/unaligned_splitter.sv
module unaligned_splitter
  import ua_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          N_WINDOWS = 2,
  parameter logic [63:0] WIN_BASES = {32'h4200_0000, 32'h2200_0000},
  parameter int          WIN_BITS  = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_unaligned_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [31:0]       req_wdata,
  input  logic              req_multi,
  input  logic              req_stack,
  input  logic              req_excl,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_fault,
  output logic              rsp_err,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_write,
  output logic [3:0]        bus_strb,
  output logic [31:0]       bus_wdata,
  input  logic              bus_rvalid,
  input  logic [31:0]       bus_rdata,
  input  logic              bus_rerr
);
  localparam int WORD_W = ADDR_W - 2;

  logic              ev_accept, ev_fault_accept, ev_beat0_accept;
  logic              cur_split, beat_sel, fault_c, split_c;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        size_q;
  logic              write_q;
  logic [31:0]       wdata_q, rbuf_lo, rbuf_hi;
  logic [31:0]       wd_lo, wd_hi, rd_joined;
  logic [3:0]        strb_lo, strb_hi;
  logic [WORD_W-1:0] word_sel;

  assign ev_accept       = req_valid && req_ready;
  assign ev_fault_accept = ev_accept && fault_c;

  ua_classify #(
    .ADDR_W(ADDR_W), .N_WINDOWS(N_WINDOWS), .WIN_BASES(WIN_BASES), .WIN_BITS(WIN_BITS)
  ) u_classify (
    .addr(req_addr), .size(req_size), .cfg_en(cfg_unaligned_en),
    .multi(req_multi), .stack(req_stack), .excl(req_excl),
    .fault(fault_c), .split(split_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      size_q  <= SZ_BYTE;
      write_q <= 1'b0;
      wdata_q <= '0;
    end else if (ev_accept) begin
      addr_q  <= req_addr;
      size_q  <= req_size;
      write_q <= req_write;
      wdata_q <= req_wdata;
    end
  end

  ua_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_fire(ev_accept), .fault_c(fault_c), .split_c(split_c),
    .bus_ready(bus_ready), .bus_rvalid(bus_rvalid), .bus_rerr(bus_rerr), .bus_rdata(bus_rdata),
    .req_ready(req_ready), .bus_valid(bus_valid), .beat_sel(beat_sel),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_err(rsp_err),
    .cur_split(cur_split), .beat0_accept(ev_beat0_accept),
    .rbuf_lo(rbuf_lo), .rbuf_hi(rbuf_hi)
  );

  ua_lane_map u_lanes (
    .off(addr_q[1:0]), .size(size_q), .wdata(wdata_q),
    .rd_lo(rbuf_lo), .rd_hi(rbuf_hi),
    .wd_lo(wd_lo), .wd_hi(wd_hi), .strb_lo(strb_lo), .strb_hi(strb_hi),
    .rd_joined(rd_joined)
  );

  assign word_sel  = addr_q[ADDR_W-1:2] + WORD_W'(beat_sel);
  assign bus_addr  = {word_sel, 2'b00};
  assign bus_write = write_q;
  assign bus_strb  = beat_sel ? strb_hi : strb_lo;
  assign bus_wdata = beat_sel ? wd_hi : wd_lo;
  assign rsp_rdata = (write_q || rsp_fault) ? 32'h0 : rd_joined;

endmodule

// File: rtl/ua_checker.sv
module ua_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_fault,
  input logic              rsp_err,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        bus_strb,
  input logic              ev_fault_accept,
  input logic              ev_beat0_accept,
  input logic              cur_split
);

  p_aligned_xfer_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_addr[1:0] == 2'b00) && (bus_strb != 4'h0));

  p_next_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_beat0_accept && cur_split |=> bus_valid && (bus_addr == $past(bus_addr) + ADDR_W'(4)));

  p_hold_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_strb));

  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_top_lane_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_beat0_accept && cur_split |-> bus_strb[3]);

  p_fault_fast_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fault_accept |=> rsp_valid && rsp_fault && !bus_valid);

  p_err_not_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_err && rsp_fault));

  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> !req_ready);

  p_reopen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready);

endmodule

bind unaligned_splitter ua_checker #(.ADDR_W(ADDR_W)) u_ua_checker (.*);

// File: tb/test_unaligned_splitter.sv
module test_unaligned_splitter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_unaligned_en = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        req_multi = 1'b0, req_stack = 1'b0, req_excl = 1'b0;
  logic        rsp_valid, rsp_fault, rsp_err;
  logic [31:0] rsp_rdata;
  logic        bus_valid, bus_write;
  logic        bus_ready;
  logic [31:0] bus_addr, bus_wdata;
  logic [3:0]  bus_strb;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic        bus_rerr;

  always #2 clk = ~clk;

  unaligned_splitter i_unaligned_splitter (
    .clk(clk), .rst_n(rst_n), .cfg_unaligned_en(cfg_unaligned_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_size(req_size),
    .req_write(req_write), .req_wdata(req_wdata), .req_multi(req_multi),
    .req_stack(req_stack), .req_excl(req_excl),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault), .rsp_err(rsp_err),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr), .bus_write(bus_write),
    .bus_strb(bus_strb), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .bus_rerr(bus_rerr)
  );

  int compared = 0;
  int mismatched = 0;

  // ---------------- bus model ----------------
  logic [7:0] bmem [0:63];
  logic [7:0] emem [0:63];
  int  cyc = 0;
  int  stall_mode = 0;
  int  err_word = -1;
  int  xfers = 0;
  int  last_acc = 0, prev_acc = 0;

  assign bus_ready = (stall_mode == 0) ? 1'b1 : (cyc[0] ^ cyc[2]);

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rerr   <= 1'b0;
      bus_rdata  <= '0;
      for (int i = 0; i < 64; i++) bmem[i] <= 8'(i * 37 + 5);
    end else begin
      bus_rvalid <= bus_valid && bus_ready;
      if (bus_valid && bus_ready) begin
        xfers    <= xfers + 1;
        prev_acc <= last_acc;
        last_acc <= cyc;
        if (err_word >= 0 && bus_addr[5:2] == err_word[3:0]) begin
          bus_rerr  <= 1'b1;
          bus_rdata <= 32'hDEAD_BEEF;
        end else begin
          bus_rerr  <= 1'b0;
          bus_rdata <= {bmem[{bus_addr[5:2], 2'd3}], bmem[{bus_addr[5:2], 2'd2}],
                        bmem[{bus_addr[5:2], 2'd1}], bmem[{bus_addr[5:2], 2'd0}]};
          if (bus_write)
            for (int k = 0; k < 4; k++)
              if (bus_strb[k]) bmem[{bus_addr[5:2], 2'(k)}] <= bus_wdata[8*k +: 8];
        end
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic access(input string ftag, input logic [31:0] a, input logic [1:0] sz,
                        input logic wr, input logic [31:0] wd,
                        input logic fm, input logic fs, input logic fx, input int errw);
    int   nb, off, n, x0, w0, w1, idx;
    logic mis, split, bb, efault, eerr;
    logic [31:0] erd;
    nb    = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    off   = int'(a[1:0]);
    mis   = (sz != 2'd3) && ((a % nb) != 0);
    split = (sz != 2'd3) && (off + nb > 4);
    bb    = (a[31:25] == 7'h11) || (a[31:25] == 7'h21);
    efault = (sz == 2'd3) || (mis && (!cfg_unaligned_en || fm || fs || fx || bb));
    w0 = int'(a[5:2]);
    w1 = (w0 + 1) % 16;
    eerr = !efault && errw >= 0 && (errw == w0 || (split && errw == w1));
    erd = '0;
    for (int i = 0; i < nb; i++) begin
      idx = (int'(a[5:0]) + i) % 64;
      erd = erd | (32'(emem[idx]) << (8 * i));
      if (wr && !efault && !(errw >= 0 && (idx / 4) == errw)) emem[idx] = wd[8*i +: 8];
    end
    err_word = errw;
    @(negedge clk);
    x0 = xfers;
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr; req_wdata = wd;
    req_multi = fm; req_stack = fs; req_excl = fx;
    @(posedge clk);
    #1 req_valid = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!rsp_valid && n < 200);
    chk("R11 response arrives", 32'(rsp_valid), 32'd1);
    chk(ftag, 32'(rsp_fault), 32'(efault));
    chk("R8 error flag", 32'(rsp_err), 32'(eerr));
    chk(split ? "R2 transfer count" : "R1 transfer count",
        32'(xfers - x0), efault ? 32'd0 : (split ? 32'd2 : 32'd1));
    if (efault) chk("R5 fault latency", 32'(n), 32'd1);
    if (!wr && !efault && !eerr) chk("R3 read data", rsp_rdata, erd);
    if (wr || efault) chk("R3 rdata zero", rsp_rdata, 32'h0);
    if (split && !efault && stall_mode == 0) chk("R2 back-to-back", 32'(last_acc - prev_acc), 32'd1);
    if (wr) begin
      int bad;
      bad = 0;
      for (int i = 0; i < 64; i++) if (bmem[i] !== emem[i]) bad++;
      chk("R4 memory image", 32'(bad), 32'd0);
    end
    @(negedge clk);
    chk("R11 ready after response", 32'(req_ready), 32'd1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : main
    logic [31:0] wd;
    for (int i = 0; i < 64; i++) emem[i] = 8'(i * 37 + 5);
    repeat (3) @(negedge clk);
    chk("R10 reset req_ready", 32'(req_ready), 32'd1);
    chk("R10 reset bus_valid", 32'(bus_valid), 32'd0);
    chk("R10 reset rsp_valid", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // full sweep: config, stall, size, offset, direction
    for (int cfg = 0; cfg < 2; cfg++)
      for (int st = 0; st < 2; st++)
        for (int sz = 0; sz < 4; sz++)
          for (int off = 0; off < 4; off++)
            for (int wr = 0; wr < 2; wr++) begin
              cfg_unaligned_en = cfg[0];
              stall_mode = st;
              wd = 32'h1000_0000 * (sz + 1) + 32'h0101_0101 * off + 32'h00A5_5A00 * wr + 32'(cfg * 7 + st);
              access(sz == 3 ? "R9 bad size fault" : "R5 config fault",
                     32'h2000_0010 + 32'(4 * st) + 32'(off), 2'(sz), wr[0], wd, 1'b0, 1'b0, 1'b0, -1);
            end

    // restricted access classes
    cfg_unaligned_en = 1'b1;
    stall_mode = 0;
    for (int f = 0; f < 3; f++)
      for (int sz = 1; sz < 3; sz++)
        for (int off = 0; off < 4; off++)
          for (int wr = 0; wr < 2; wr++)
            access("R6 class fault", 32'h2000_0020 + 32'(off), 2'(sz), wr[0],
                   32'hC0DE_0000 + 32'(f * 16 + off), f == 0, f == 1, f == 2, -1);

    // alias windows
    access("R7 alias byte passes",    32'h2200_0011, 2'd0, 1'b1, 32'h0000_00E1, 1'b0, 1'b0, 1'b0, -1);
    access("R7 alias half faults",    32'h2200_0011, 2'd1, 1'b1, 32'h0000_E2E3, 1'b0, 1'b0, 1'b0, -1);
    access("R7 alias word aligned",   32'h4200_0018, 2'd2, 1'b0, 32'h0,         1'b0, 1'b0, 1'b0, -1);
    access("R7 alias word faults",    32'h4200_0016, 2'd2, 1'b0, 32'h0,         1'b0, 1'b0, 1'b0, -1);
    access("R7 alias half at top",    32'h43FF_FFF3, 2'd1, 1'b0, 32'h0,         1'b0, 1'b0, 1'b0, -1);
    access("R7 outside window",       32'h2400_0013, 2'd1, 1'b0, 32'h0,         1'b0, 1'b0, 1'b0, -1);

    // bus errors on each half of split and on single transfers
    for (int st = 0; st < 2; st++)
      for (int wr = 0; wr < 2; wr++)
        for (int off = 1; off < 4; off++) begin
          stall_mode = st;
          access("R8 split, low word fails",  32'h2000_0028 + 32'(off), 2'd2, wr[0],
                 32'h5511_2200 + 32'(off), 1'b0, 1'b0, 1'b0, 10);
          access("R8 split, high word fails", 32'h2000_0028 + 32'(off), 2'd2, wr[0],
                 32'h6611_3300 + 32'(off), 1'b0, 1'b0, 1'b0, 11);
          access("R8 single fails",           32'h2000_0028, 2'd0, wr[0],
                 32'h0000_0077, 1'b0, 1'b0, 1'b0, 10);
        end
    stall_mode = 0;
    access("R3 readback after errors", 32'h2000_002B, 2'd2, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, -1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule